// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Output Unpacker

This block sits on the read side of a 36-bit queue and hands each long word to a narrower consumer. A static size input picks one of three output widths. In long mode each long word goes out in one beat. In word mode it goes out as two 18-bit beats, and in byte mode as four 9-bit beats. Both the upstream side and the downstream side use a valid/ready handshake. The block holds one long word and takes the next one from upstream only when the downstream side accepts the final piece of the current one.

The order of the pieces is set by a select level that is captured once, on the rising edge of the active-low reset. A high level sends the most significant piece first. A low level sends the least significant piece first. Narrow pieces come out right-aligned on the 36-bit output bus, and the unused upper bits are zero.

Top module: `bus_unpacker`

## Requirements
- R1: The order select is sampled when `rst_ni` rises and is held from then on. Later changes on `endian_sel_i` have no effect on the output order.
- R2: With a high sampled select (big-endian), the most significant piece of each long word is output first and the least significant piece is output last.
- R3: With a low sampled select (little-endian), the least significant piece (bits 8:0 for bytes, bits 17:0 for words) is output first and the most significant piece is output last.
- R4: When `size_sel_i` is 2'b00 (long), or the unused code 2'b11, each long word is output whole in one beat, whatever the sampled select level.
- R5: When `size_sel_i` is 2'b01 (word), each long word is output as two beats on `out_data_o[17:0]`, and bits 35:18 are zero.
- R6: When `size_sel_i` is 2'b10 (byte), each long word is output as four beats on `out_data_o[8:0]`, and bits 35:9 are zero.
- R7: `in_ready_o` is high only when no long word is held, or when the final piece of the held word is accepted in the same cycle. No piece is ever dropped or repeated.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays stable on the next cycle.
- R9: Reset empties the holding register and clears the piece counter. After reset `out_valid_o` is low and `in_ready_o` is high, and the first piece after reset is the first piece of a new long word, even if reset came in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its rising edge captures the order select |
| endian_sel_i | input | 1 | Order select: 1 = big-endian, 0 = little-endian |
| size_sel_i | input | 2 | Output size: 00 = long, 01 = word, 10 = byte, 11 = long |
| in_valid_i | input | 1 | Upstream long word valid |
| in_data_i | input | 36 | Upstream long word |
| in_ready_o | output | 1 | Block accepts a long word this cycle |
| out_valid_o | output | 1 | Output piece valid |
| out_data_o | output | 36 | Output piece, right-aligned, upper bits zero |
| out_ready_i | input | 1 | Downstream accepts the piece |

## Verification
Each output size is run with both captured order levels. In every lane of every long word the bench puts a different value, so a piece that is swapped, repeated or shifted into the wrong lane shows up as a wrong value. Each combination runs three handshake patterns: full throughput, pseudo-random stalls on both sides, and a slow consumer. Full throughput exercises the fetch of the next long word in the same cycle as the last piece. Random stalls exercise data holding and the ready gating. The slow consumer keeps the upstream waiting across several pieces. Two further cases cover the capture rule and reset: the select input is toggled after reset to show it is ignored, and reset is applied in the middle of a word to show that the next word starts again at its first piece.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;
endpackage

// File: rtl/unpk_order_cap.sv
// Order select is captured on the rising edge of reset only.
module unpk_order_cap (
  input  logic rst_ni,
  input  logic endian_sel_i,
  output logic big_o
);
  logic big_q;

  always_ff @(posedge rst_ni) begin
    big_q <= endian_sel_i;
  end

  assign big_o = big_q;
endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
  import unpk_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CNT_W = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  size_e            size_i,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             load_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             full_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  logic             last_piece;
  logic             out_fire;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: last_idx = CNT_W'(LANES - 1);
      SZ_WORD: last_idx = CNT_W'(1);
      default: last_idx = '0;
    endcase
  end

  assign last_piece = (cnt_q == last_idx);
  assign out_fire   = full_q && out_ready_i;
  // refill only when the current long word is fully drained
  assign in_ready_o = !full_q || (out_fire && last_piece);
  assign load_o     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (load_o)                       full_q <= 1'b1;
      else if (out_fire && last_piece)  full_q <= 1'b0;
      if (out_fire)                     cnt_q  <= last_piece ? '0 : cnt_q + 1'b1;
    end
  end

  assign full_o = full_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/unpk_lane_sel.sv
module unpk_lane_sel
  import unpk_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned W     = LANE_W * LANES,
  localparam int unsigned HW    = W / 2,
  localparam int unsigned CNT_W = $clog2(LANES)
) (
  input  logic [W-1:0]     data_i,
  input  size_e            size_i,
  input  logic             big_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]     data_o
);
  logic [LANE_W-1:0] lanes [LANES];
  logic [HW-1:0]     halves [2];
  logic [CNT_W-1:0]  lane_idx;
  logic              half_idx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = data_i[g*LANE_W +: LANE_W];
  end
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halves[h] = data_i[h*HW +: HW];
  end

  assign lane_idx = big_i ? CNT_W'(LANES - 1) - cnt_i : cnt_i;
  assign half_idx = big_i ? ~cnt_i[0] : cnt_i[0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = W'(lanes[lane_idx]);
      SZ_WORD: data_o = W'(halves[half_idx]);
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/bus_unpacker.sv
module bus_unpacker
  import unpk_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned W     = LANE_W * LANES,
  localparam int unsigned CNT_W = $clog2(LANES)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         endian_sel_i,
  input  logic [1:0]   size_sel_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  input  logic         out_ready_i
);
  size_e            size;
  logic             big_q;
  logic             load;
  logic             full;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     hold_q;

  assign size = size_e'(size_sel_i);

  unpk_order_cap u_cap (
    .rst_ni       (rst_ni),
    .endian_sel_i (endian_sel_i),
    .big_o        (big_q)
  );

  unpk_ctrl #(.LANES(LANES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .size_i      (size),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .load_o      (load),
    .full_o      (full),
    .cnt_o       (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (load) hold_q <= in_data_i;
  end

  unpk_lane_sel #(.LANE_W(LANE_W), .LANES(LANES)) u_sel (
    .data_i (hold_q),
    .size_i (size),
    .big_i  (big_q),
    .cnt_i  (cnt),
    .data_o (out_data_o)
  );

  assign out_valid_o = full;
endmodule

// File: rtl/bus_unpacker_chk.sv
module bus_unpacker_chk #(
  parameter int unsigned W = 36,
  parameter int unsigned LANE_W = 9
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   size_sel_i,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] out_data_o,
  input logic         big_i
);
  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  a_r8_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r7_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && out_valid_o |-> out_ready_i);

  a_r6_byte_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && size_sel_i == 2'b10 |-> out_data_o[W-1:LANE_W] == '0);

  a_r5_word_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && size_sel_i == 2'b01 |-> out_data_o[W-1:W/2] == '0);

  a_r1_order_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> $stable(big_i));
endmodule

bind bus_unpacker bus_unpacker_chk #(.W(W), .LANE_W(LANE_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .size_sel_i  (size_sel_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .big_i       (big_q)
);

// File: tb/bus_unpacker_tb_top.sv
`timescale 1ns/1ps
module bus_unpacker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        endian_sel_i = 1'b0;
  logic [1:0]  size_sel_i = 2'b00;
  logic        in_valid_i = 1'b0;
  logic [35:0] in_data_i = '0;
  logic        in_ready_o;
  logic        out_valid_o;
  logic [35:0] out_data_o;
  logic        out_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [35:0] exp_q[$];
  logic        cur_big;

  always #4 clk_i = ~clk_i;

  bus_unpacker dut_i (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] gen_word(input int s, input int pat);
    logic [35:0] d;
    for (int k = 0; k < 4; k++) d[k*9 +: 9] = 9'(s*4 + k + 1) ^ 9'(pat * 9'h0A5);
    return d;
  endfunction

  task automatic push_pieces(input logic [35:0] d, input int sz);
    int n = (sz == 2) ? 4 : (sz == 1) ? 2 : 1;
    int w = 36 / n;
    for (int k = 0; k < n; k++) begin
      int idx = cur_big ? n - 1 - k : k;
      logic [35:0] m = (n == 1) ? 36'hF_FFFF_FFFF : ((36'd1 << w) - 36'd1);
      exp_q.push_back((d >> (idx * w)) & m);
    end
  endtask

  task automatic do_reset(input logic big);
    @(negedge clk_i);
    rst_ni = 1'b0; in_valid_i = 1'b0; out_ready_i = 1'b0;
    endian_sel_i = big;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cur_big = big;
    exp_q.delete();
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R9 valid after reset", 36'(out_valid_o), 36'd0);
    check(in_ready_o == 1'b1, "R9 ready after reset", 36'(in_ready_o), 36'd1);
  endtask

  // mode: 0 full rate, 1 random both sides, 2 slow consumer
  task automatic run_phase(input int sz, input int nwords, input int mode, input int pat, input bit flip_sel);
    int sent = 0;
    bit stall_prev = 0;
    logic [35:0] prev = '0;
    string tag;
    size_sel_i = 2'(sz);
    tag = (sz == 2) ? "R6" : (sz == 1) ? "R5" : "R4";
    while (sent < nwords || exp_q.size() > 0) begin
      if (flip_sel) endian_sel_i = ~endian_sel_i;
      in_valid_i  = (sent < nwords) && (mode == 1 ? lfsr[0] : 1'b1);
      in_data_i   = gen_word(sent, pat);
      out_ready_i = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[3] : (lfsr[2:0] == 3'd0);
      #1;
      check(out_valid_o == (exp_q.size() > 0), "R7 valid vs pending", 36'(out_valid_o), 36'(exp_q.size() > 0));
      if (stall_prev)
        check(out_valid_o && out_data_o == prev, "R8 hold on stall", out_data_o, prev);
      if (out_valid_o && out_ready_i) begin
        logic [35:0] e = exp_q.pop_front();
        check(out_data_o == e, {tag, cur_big ? " R2" : " R3", " R1 piece"}, out_data_o, e);
      end
      if (in_valid_i && in_ready_o) begin
        check(exp_q.size() == 0, "R7 fetch only after last piece", 36'(exp_q.size()), 36'd0);
        push_pieces(in_data_i, sz);
        sent++;
      end
      stall_prev = out_valid_o && !out_ready_i;
      prev = out_data_o;
      @(negedge clk_i);
    end
    in_valid_i = 1'b0; out_ready_i = 1'b0;
  endtask

  initial begin
    cur_big = 1'b0;
    for (int b = 0; b < 2; b++) begin
      do_reset(b[0]);
      for (int sz = 0; sz < 3; sz++)
        for (int mode = 0; mode < 3; mode++)
          run_phase(sz, 12, mode, sz * 3 + mode + b, 1'b0);
    end
    // R4: unused size code behaves as long
    run_phase(3, 6, 1, 7, 1'b0);
    // R1: select toggles after capture; order must not follow it
    do_reset(1'b1);
    run_phase(2, 10, 1, 5, 1'b1);
    do_reset(1'b0);
    run_phase(1, 10, 1, 6, 1'b1);
    // R9: reset mid-word, next output starts a fresh long word
    size_sel_i = 2'b10;
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = 36'h1_2345_6789;
    @(negedge clk_i);
    in_valid_i = 1'b0; out_ready_i = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    do_reset(1'b0);
    run_phase(2, 4, 0, 9, 1'b0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL R7 watchdog: actual hang expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule